// File: doc/BRIEF.md
# Crate Driver Host Command and Status Interface

This block is the host-facing front end of a serial crate-bus driver. A host writes the 16-bit segment address of a command package to the start port. The offset part of the package address is always zero, so only the segment is sent. Each written segment goes into a four-entry queue, which lets more than one writer line up work. Whenever the controller is idle and the queue holds an entry, the oldest segment is handed to the packet sequencer with a one-cycle start pulse.

While a package runs, the block counts clock cycles against a fixed budget. If the sequencer does not report completion within the budget, the block sends it a one-cycle abort pulse and marks a package timeout. Error pulses from the sequencer and the attention (LAM) level are captured as sticky flags for the running package. A new package start clears these flags.

A status port shows a busy-not flag and the flags of the last package. The flag bits carry meaning only while busy-not is set. While the controller is busy they read as zero. The host bus is reduced to port-write and port-read strobes with an address and a data word.

The controller has four states:
- `ST_IDLE`: waiting. It moves to `ST_LAUNCH` when the queue is non-empty, and the head entry is popped in that cycle.
- `ST_LAUNCH`: drives the start pulse, clears the flags and reloads the watchdog. It always moves to `ST_RUN`.
- `ST_RUN`: waits for the package to end. It returns to `ST_IDLE` on sequencer done, and moves to `ST_ABORT` when the budget runs out.
- `ST_ABORT`: drives the abort pulse, sets the package timeout flag and returns to `ST_IDLE`.

Top module: `crate_host_if`

## Requirements
- R1: After reset the status port reads 80h (only busy-not set), `seq_start` and `seq_abort` are 0 and `fifo_ovf` is 0.
- R2: A host write to address 120h queues `host_wdata` as a segment. Segments are started in write order, each with a one-cycle `seq_start` pulse while `seq_seg` holds that segment, and only from the idle state.
- R3: The queue holds 4 segments. A start-port write while it holds 4 is dropped and sets `fifo_ovf`, which stays 1 until reset.
- R4: A read at address 122h returns the status byte. Bit 7 (busy-not) is 1 when idle and 0 from the start pulse until the package ends. While busy, bits 6..0 read as 0.
- R5: Bit 0 (done) is 1 after a package ends through `seq_done`.
- R6: Pulses on `err_hbus_to`, `err_crate_to` and `err_buf_ovf` during a running package set bit 3, bit 4 and bit 5 respectively. A high `lam_in` sets bit 2. All of these bits are sticky until the next start.
- R7: Bit 1 (summary error) is the OR of bits 3, 5 and 6. Bit 4 does not contribute to it.
- R8: If `seq_done` has not arrived after `TIMEOUT_CYC` running cycles, `seq_abort` pulses for one cycle, 1 + `TIMEOUT_CYC` cycles after the start pulse. The controller then goes idle with bit 6 (package timeout) set and bit 0 clear.
- R9: `seq_done` in the last cycle of the budget ends the package normally: no abort, bit 0 set, bit 6 clear.
- R10: All flag bits 6..0 are cleared when the next package starts.
- R11: Writes to any address other than 120h, and reads of any address, queue nothing. A read of any address other than 122h returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host port-write strobe |
| host_rd | input | 1 | Host port-read strobe |
| host_addr | input | ADDR_W | Host I/O port address |
| host_wdata | input | SEG_W | Host write data (package segment) |
| host_rdata | output | 8 | Status byte on a read of 122h, otherwise 0 |
| seq_start | output | 1 | One-cycle package start to the sequencer |
| seq_seg | output | SEG_W | Segment of the package being started or run |
| seq_done | input | 1 | Sequencer reports package complete |
| seq_abort | output | 1 | One-cycle abort on watchdog expiry |
| err_hbus_to | input | 1 | Host-bus timeout error pulse |
| err_crate_to | input | 1 | Crate-bus timeout error pulse |
| err_buf_ovf | input | 1 | Buffer offset overflow error pulse |
| lam_in | input | 1 | Attention (LAM) level from the branch |
| fifo_ovf | output | 1 | Sticky flag: a start write was dropped |

## Verification
The assertions check the following on every cycle:
- start and abort are single-cycle pulses;
- an abort only follows a running cycle, and the watchdog count never reaches its budget while running;
- the flags are zero right after a start;
- a full queue never grows, and its overflow flag stays set;
- status reads taken while busy show nothing but zeros.

Some behaviours can only be shown by the bench's scenarios:
- the order in which queued segments are started, and that a dropped fifth write never starts;
- the exact abort cycle, and the race between done and the last budget cycle;
- the summary bit's exclusion of the crate-bus timeout.

// File: rtl/crate_host_pkg.sv
package crate_host_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2,
        ST_ABORT  = 2'd3
    } ctl_state_t;

    typedef struct packed {
        logic pto;
        logic boo;
        logic cbto;
        logic hbto;
        logic lam;
        logic done;
    } pkg_flags_t;

    localparam int unsigned STAT_W = 8;

endpackage

// File: rtl/chi_fifo.sv
module chi_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
            if (push && full) ovf <= 1'b1;
        end
    end

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full && ovf) else $error("full fifo accepted a write"); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf) else $error("overflow flag cleared"); // R3
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty) else $error("pop from empty fifo"); // R2

endmodule

// File: rtl/chi_watchdog.sv
module chi_watchdog #(
    parameter int unsigned TIMEOUT_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == CW'(TIMEOUT_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (reload) cnt <= '0;
        else if (run && !expire) cnt <= cnt + CW'(1);
    end

    AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < CW'(TIMEOUT_CYC))) else $error("watchdog past budget"); // R8

endmodule

// File: rtl/chi_flags.sv
module chi_flags
    import crate_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       capture,
    input  logic       set_done,
    input  logic       set_pto,
    input  logic       hbto_in,
    input  logic       cbto_in,
    input  logic       boo_in,
    input  logic       lam_lvl,
    output pkg_flags_t flags
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            flags <= '0;
        end else begin
            if (capture) begin
                if (hbto_in) flags.hbto <= 1'b1;
                if (cbto_in) flags.cbto <= 1'b1;
                if (boo_in)  flags.boo  <= 1'b1;
                if (lam_lvl) flags.lam  <= 1'b1;
            end
            if (set_done) flags.done <= 1'b1;
            if (set_pto)  flags.pto  <= 1'b1;
        end
    end

    AST_DONE_PTO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags.done && flags.pto)) else $error("done and timeout both set"); // R8

endmodule

// File: rtl/chi_ctrl.sv
module chi_ctrl
    import crate_host_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty,
    input  logic seq_done,
    input  logic expire,
    output logic pop,
    output logic start,
    output logic abort,
    output logic busy,
    output logic reload,
    output logic run,
    output logic set_done,
    output logic set_pto
);
    ctl_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!fifo_empty) nxt = ST_LAUNCH;
            ST_LAUNCH: nxt = ST_RUN;
            ST_RUN: begin
                if (seq_done)    nxt = ST_IDLE;
                else if (expire) nxt = ST_ABORT;
            end
            ST_ABORT:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        pop      = 1'b0;
        start    = 1'b0;
        abort    = 1'b0;
        busy     = 1'b1;
        reload   = 1'b0;
        run      = 1'b0;
        set_done = 1'b0;
        set_pto  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                pop  = !fifo_empty;
            end
            ST_LAUNCH: begin
                start  = 1'b1;
                reload = 1'b1;
            end
            ST_RUN: begin
                run      = 1'b1;
                set_done = seq_done;
            end
            ST_ABORT: begin
                abort   = 1'b1;
                set_pto = 1'b1;
            end
            default: busy = 1'b1;
        endcase
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start && run) else $error("start not a single pulse"); // R2
    AST_ABORT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> $past(run) && !$past(seq_done)) else $error("abort without running"); // R8
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort && !busy) else $error("abort not a single pulse"); // R8
    AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && seq_done) |=> !abort) else $error("abort despite done"); // R9

endmodule

// File: rtl/crate_host_if.sv
module crate_host_if
    import crate_host_pkg::*;
#(
    parameter int unsigned             ADDR_W      = 12,
    parameter int unsigned             SEG_W       = 16,
    parameter int unsigned             QDEPTH      = 4,
    parameter int unsigned             TIMEOUT_CYC = 50000,
    parameter logic [ADDR_W-1:0]       START_PORT  = 'h120,
    parameter logic [ADDR_W-1:0]       STAT_PORT   = 'h122
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [SEG_W-1:0]  host_wdata,
    output logic [STAT_W-1:0] host_rdata,
    output logic              seq_start,
    output logic [SEG_W-1:0]  seq_seg,
    input  logic              seq_done,
    output logic              seq_abort,
    input  logic              err_hbus_to,
    input  logic              err_crate_to,
    input  logic              err_buf_ovf,
    input  logic              lam_in,
    output logic              fifo_ovf
);
    logic             push, pop, empty, full;
    logic [SEG_W-1:0] head;
    logic             busy, reload, run, set_done, set_pto, expire;
    logic             rd_stat;
    logic             summary;
    logic [STAT_W-1:0] status;
    pkg_flags_t       flags;

    assign push = host_wr && (host_addr == START_PORT);

    chi_fifo #(.W(SEG_W), .DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(host_wdata),
        .dout(head), .empty(empty), .full(full), .ovf(fifo_ovf)
    );

    chi_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_empty(empty), .seq_done(seq_done),
        .expire(expire), .pop(pop), .start(seq_start), .abort(seq_abort),
        .busy(busy), .reload(reload), .run(run), .set_done(set_done),
        .set_pto(set_pto)
    );

    chi_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
        .clk(clk), .rst_n(rst_n), .reload(reload), .run(run), .expire(expire)
    );

    chi_flags u_flags (
        .clk(clk), .rst_n(rst_n), .clear(reload), .capture(run),
        .set_done(set_done), .set_pto(set_pto), .hbto_in(err_hbus_to),
        .cbto_in(err_crate_to), .boo_in(err_buf_ovf), .lam_lvl(lam_in),
        .flags(flags)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)   seq_seg <= '0;
        else if (pop) seq_seg <= head;
    end

    assign summary = flags.hbto | flags.boo | flags.pto;
    assign rd_stat = host_rd && (host_addr == STAT_PORT);

    always_comb begin
        if (busy) status = '0;
        else status = {1'b1, flags.pto, flags.boo, flags.cbto, flags.hbto,
                       flags.lam, summary, flags.done};
        host_rdata = rd_stat ? status : '0;
    end

    AST_BUSY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && busy) |-> (host_rdata == '0)) else $error("busy read leaked bits"); // R4
    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> (flags == '0)) else $error("flags not cleared at start"); // R10
    AST_START_FROM_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> $past(pop)) else $error("start without queued segment"); // R2

endmodule

// File: tb/sim_crate_host_if.sv
module sim_crate_host_if;
    localparam int unsigned TO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [11:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        seq_start, seq_abort, fifo_ovf;
    logic [15:0] seq_seg;
    logic        seq_done = 1'b0, err_hbus_to = 1'b0, err_crate_to = 1'b0;
    logic        err_buf_ovf = 1'b0, lam_in = 1'b0;

    int checks = 0, errors = 0;
    logic [15:0] expq[$];
    logic [7:0]  st;

    crate_host_if #(.TIMEOUT_CYC(TO)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .seq_start(seq_start), .seq_seg(seq_seg), .seq_done(seq_done),
        .seq_abort(seq_abort), .err_hbus_to(err_hbus_to),
        .err_crate_to(err_crate_to), .err_buf_ovf(err_buf_ovf),
        .lam_in(lam_in), .fifo_ovf(fifo_ovf)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop on every start
    always @(negedge clk) begin
        if (rst_n && seq_start) begin
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2/R11: actual start %h expected none", seq_seg);
            end else begin
                chk("R2 start order", seq_seg, expq.pop_front());
            end
        end
    end

    task automatic host_write(input logic [11:0] a, input logic [15:0] d, input bit accept);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        if (accept) expq.push_back(d);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic read_port(input logic [11:0] a, output logic [7:0] v);
        host_rd = 1'b1; host_addr = a;
        #1 v = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic wait_start();
        while (!seq_start) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_port(12'h122, st);
        chk("R1 reset status", st, 8'h80);
        chk("R1 reset start", seq_start, 0);
        chk("R1 reset ovf", fifo_ovf, 0);

        // package A: crate timeout only
        host_write(12'h120, 16'h1A00, 1);
        wait_start();
        @(negedge clk);
        read_port(12'h122, st);
        chk("R4 busy read", st, 8'h00);
        pulse(err_crate_to);
        pulse(seq_done);
        read_port(12'h122, st);
        chk("R5 R6 R7 cbto not in summary", st, 8'h91);

        // package B: buffer overflow + lam
        host_write(12'h120, 16'h2B00, 1);
        wait_start();
        @(negedge clk);
        err_buf_ovf = 1'b1; lam_in = 1'b1;
        @(negedge clk);
        err_buf_ovf = 1'b0; lam_in = 1'b0;
        pulse(seq_done);
        read_port(12'h122, st);
        chk("R6 R7 R10 boo lam", st, 8'hA7);

        // package C: host-bus timeout
        host_write(12'h120, 16'h3C00, 1);
        wait_start();
        @(negedge clk);
        pulse(err_hbus_to);
        pulse(seq_done);
        read_port(12'h122, st);
        chk("R6 R7 hbto", st, 8'h8B);

        // package D: watchdog expiry
        host_write(12'h120, 16'h4D00, 1);
        wait_start();
        n = 0;
        do begin @(negedge clk); n++; end while (!seq_abort && n < 200);
        chk("R8 abort cycle", 16'(n), 16'(TO + 1));
        @(negedge clk);
        chk("R8 abort single", seq_abort, 0);
        read_port(12'h122, st);
        chk("R8 R7 timeout status", st, 8'hC2);

        // package E: done in last budget cycle
        host_write(12'h120, 16'h5E00, 1);
        wait_start();
        repeat (TO) @(negedge clk);
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
        chk("R9 no abort", seq_abort, 0);
        read_port(12'h122, st);
        chk("R9 R10 done wins", st, 8'h81);

        // ignored accesses
        host_write(12'h124, 16'h6F00, 0);
        host_rd = 1'b1; host_addr = 12'h120;
        #1 chk("R11 other read zero", host_rdata, 0);
        @(negedge clk);
        host_rd = 1'b0;
        repeat (10) @(negedge clk);
        chk("R11 nothing queued", 16'(expq.size()), 0);
        read_port(12'h122, st);
        chk("R11 status unchanged", st, 8'h81);

        // queue fill and overflow
        host_write(12'h120, 16'h7000, 1);
        wait_start();
        @(negedge clk);
        chk("R3 ovf clear", fifo_ovf, 0);
        for (int i = 1; i <= 4; i++) host_write(12'h120, 16'h7000 + 16'(i), 1);
        chk("R3 no ovf at four", fifo_ovf, 0);
        host_write(12'h120, 16'h7FFF, 0);
        chk("R3 ovf set", fifo_ovf, 1);
        pulse(seq_done);
        for (int i = 0; i < 4; i++) begin
            wait_start();
            @(negedge clk);
            pulse(seq_done);
        end
        repeat (10) @(negedge clk);
        chk("R2 queue drained in order", 16'(expq.size()), 0);
        chk("R3 ovf sticky", fifo_ovf, 1);
        read_port(12'h122, st);
        chk("R4 idle status", st, 8'h81);

        finish_run();
    end
endmodule